// File: doc/BRIEF.md
# Loadable Modulo-N Binary Counter

A four-bit synchronous up-counter with a parallel load, an asynchronous clear, a synchronous reset, a count input, a cascade enable and a carry output. Every state change happens on the common clock. The only exception is the clear, which drives the count to zero at once.

A build parameter wraps the same counting core into one of two modulo configurations. In both, a terminal-count detector drives the core's synchronous load.

- **Modulo-7.** The detector watches for 6 and reloads 0, so the count runs 0 through 6.
- **Modulo-6.** Reset presets the count to 9, and the detector reloads 9 after 14, so the count runs 9 through 14.

The carry output marks a count of 15 while counting is enabled. It can feed the enable of a following four-bit stage.

In the modulo-7 configuration, a count outside 0..6 can only be reached through an explicit load. Any such count is sent back to 0 on the next clock edge, so the counter cannot be trapped in an unused state.

Top module: `modn_counter`

## Requirements
- R1: While `aclr` is 1, `q` is 0 without waiting for a clock edge.
- R2: A clock edge with `rst` at 1 sets `q` to the base value. The base value is 0 in the modulo-7 configuration and 9 (4'b1001) in the modulo-6 configuration.
- R3: A clock edge with `load` at 1 sets `q` to `d`, whatever `count` and `en` are.
- R4: A clock edge with `load` at 0 and both `count` and `en` at 1 adds one to `q`, unless a wrap or recovery rule applies. From 15 the count goes to 0.
- R5: A clock edge with `load` at 0 and either `count` or `en` at 0 leaves `q` unchanged, unless R9 applies.
- R6: `co` is 1 exactly when `q` is 15 and both `count` and `en` are 1. It is combinational from those inputs.
- R7: In the modulo-7 configuration, counting from 6 gives 0. The repeating sequence is 0,1,2,3,4,5,6,0.
- R8: In the modulo-6 configuration, counting from 14 gives 9. The repeating sequence is 9,10,11,12,13,14,9.
- R9: In the modulo-7 configuration, when `q` holds 7..15 and `load` is 0, the next clock edge sets `q` to 0. This happens even when counting is off.
- R10: The controls rank, from highest to lowest: `aclr`, `rst`, `load`, then counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| aclr | input | 1 | Asynchronous clear to zero, active high |
| rst | input | 1 | Synchronous reset to the base value, active high |
| load | input | 1 | Synchronous parallel load of `d` |
| count | input | 1 | Count request |
| en | input | 1 | Cascade enable; counting needs both `count` and `en` |
| d | input | 4 | Parallel load data |
| q | output | 4 | Current count |
| co | output | 1 | Carry out: count is 15 while counting is enabled |

## Verification
The assertions check the following every cycle, in either configuration:
- the ranking of clear, reset, load, hold and increment;
- the wrap from the terminal count to the base value;
- the return from unused modulo-7 states within one edge;
- that carry appears only at 15 with the enable high.

Only the bench's scenarios can show the whole repeating sequence over several full periods, because that needs a reference model spanning many cycles. The same holds for the immediate, clock-free effect of a clear raised in the middle of a count, and for the behaviour of both configurations under one identical stream of stimulus.

// File: rtl/modn_pkg.sv
package modn_pkg;

    localparam int CW = 4;

    typedef logic [CW-1:0] cnt_t;

    typedef enum logic [0:0] {
        MODE_MOD7 = 1'b0,
        MODE_MOD6 = 1'b1
    } mode_e;

    typedef struct packed {
        logic ld;
        cnt_t val;
    } ldreq_t;

    function automatic cnt_t base_of(mode_e m);
        return (m == MODE_MOD6) ? cnt_t'(9) : cnt_t'(0);
    endfunction

    function automatic cnt_t term_of(mode_e m);
        return (m == MODE_MOD6) ? cnt_t'(14) : cnt_t'(6);
    endfunction

    function automatic logic out_of_range(mode_e m, cnt_t v);
        return (m == MODE_MOD7) && (v > term_of(m));
    endfunction

endpackage

// File: rtl/modn_core.sv
module modn_core
    import modn_pkg::*;
(
    input  logic   clk,
    input  logic   aclr,
    input  logic   rst,
    input  cnt_t   rst_val,
    input  ldreq_t ldreq,
    input  logic   step,
    output cnt_t   q,
    output logic   co
);

    cnt_t q_r;

    always_ff @(posedge clk or posedge aclr) begin
        if (aclr) begin
            q_r <= '0;
        end else if (rst) begin
            q_r <= rst_val;
        end else if (ldreq.ld) begin
            q_r <= ldreq.val;
        end else if (step) begin
            q_r <= q_r + cnt_t'(1);
        end
    end

    assign q  = q_r;
    assign co = step & (&q_r);

endmodule

// File: rtl/modn_term.sv
module modn_term
    import modn_pkg::*;
#(
    parameter mode_e MODE = MODE_MOD7
) (
    input  cnt_t   q,
    input  logic   load_ext,
    input  cnt_t   d,
    input  logic   step,
    output ldreq_t ldreq
);

    localparam cnt_t BASE = base_of(MODE);
    localparam cnt_t TERM = term_of(MODE);

    logic hit_term;
    logic stray;

    assign hit_term = step && (q == TERM);

    generate
        if (MODE == MODE_MOD7) begin : g_recover
            assign stray = out_of_range(MODE, q);
        end else begin : g_norecover
            assign stray = 1'b0;
        end
    endgenerate

    always_comb begin
        ldreq = '{ld: 1'b0, val: '0};
        if (load_ext) begin
            ldreq = '{ld: 1'b1, val: d};
        end else if (stray) begin
            ldreq = '{ld: 1'b1, val: BASE};
        end else if (hit_term) begin
            ldreq = '{ld: 1'b1, val: BASE};
        end
    end

endmodule

// File: rtl/modn_counter.sv
module modn_counter
    import modn_pkg::*;
#(
    parameter mode_e MODE = MODE_MOD7
) (
    input  logic          clk,
    input  logic          aclr,
    input  logic          rst,
    input  logic          load,
    input  logic          count,
    input  logic          en,
    input  logic [CW-1:0] d,
    output logic [CW-1:0] q,
    output logic          co
);

    localparam cnt_t BASE = base_of(MODE);

    logic   step;
    ldreq_t ldreq;
    cnt_t   q_w;

    assign step = count & en;

    modn_term #(.MODE(MODE)) u_term (
        .q        (q_w),
        .load_ext (load),
        .d        (d),
        .step     (step),
        .ldreq    (ldreq)
    );

    modn_core u_core (
        .clk     (clk),
        .aclr    (aclr),
        .rst     (rst),
        .rst_val (BASE),
        .ldreq   (ldreq),
        .step    (step),
        .q       (q_w),
        .co      (co)
    );

    assign q = q_w;

endmodule

// File: rtl/modn_counter_chk.sv
module modn_counter_chk
    import modn_pkg::*;
#(
    parameter mode_e MODE = MODE_MOD7
) (
    input logic          clk,
    input logic          aclr,
    input logic          rst,
    input logic          load,
    input logic          count,
    input logic          en,
    input logic [CW-1:0] d,
    input logic [CW-1:0] q,
    input logic          co
);

    localparam cnt_t BASE = base_of(MODE);
    localparam cnt_t TERM = term_of(MODE);

    AST_CLEAR_ZERO: assert property (@(posedge clk) aclr |-> (q == '0)); // R1

    AST_RESET_BASE: assert property (@(posedge clk) disable iff (aclr)
        rst |=> (q == BASE)); // R2

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (aclr || rst)
        load |=> (q == $past(d))); // R3

    AST_INCREMENT: assert property (@(posedge clk) disable iff (aclr || rst)
        (!load && count && en && q != TERM && !out_of_range(MODE, q))
        |=> (q == cnt_t'($past(q) + cnt_t'(1)))); // R4

    AST_HOLD: assert property (@(posedge clk) disable iff (aclr || rst)
        (!load && !(count && en) && !out_of_range(MODE, q)) |=> $stable(q)); // R5

    AST_CARRY_ONLY_AT_TOP: assert property (@(posedge clk) disable iff (aclr || rst)
        co |-> ((q == '1) && en && count)); // R6

    AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (aclr || rst)
        (!load && count && en && q == TERM) |=> (q == BASE)); // R7

    AST_MOD6_NEVER_PAST_TERM: assert property (@(posedge clk) disable iff (aclr || rst)
        (MODE == MODE_MOD6 && !load && q >= BASE && q <= TERM)
        |=> (q >= BASE && q <= TERM)); // R8

    AST_STRAY_RECOVER: assert property (@(posedge clk) disable iff (aclr || rst)
        (!load && out_of_range(MODE, q)) |=> (q == '0)); // R9

endmodule

bind modn_counter modn_counter_chk #(.MODE(MODE)) u_chk (
    .clk   (clk),
    .aclr  (aclr),
    .rst   (rst),
    .load  (load),
    .count (count),
    .en    (en),
    .d     (d),
    .q     (q),
    .co    (co)
);

// File: tb/modn_counter_test.sv
module modn_counter_test;
    import modn_pkg::*;

    logic       clk = 1'b0;
    logic       aclr = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic       count = 1'b0;
    logic       en = 1'b0;
    logic [3:0] d = 4'd0;
    logic [3:0] q7, q6;
    logic       co7, co6;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    modn_counter #(.MODE(MODE_MOD7)) uut (
        .clk(clk), .aclr(aclr), .rst(rst), .load(load), .count(count),
        .en(en), .d(d), .q(q7), .co(co7)
    );

    modn_counter #(.MODE(MODE_MOD6)) uut_m6 (
        .clk(clk), .aclr(aclr), .rst(rst), .load(load), .count(count),
        .en(en), .d(d), .q(q6), .co(co6)
    );

    typedef struct packed {
        logic       ld;
        logic       cnt;
        logic       ena;
        logic [3:0] dat;
        logic       c7;
        logic       c6;
        logic [3:0] e7;
        logic [3:0] e6;
    } vec_t;

    // Each row: inputs, carry before the edge, count after the edge.
    localparam vec_t VEC [16] = '{
        '{1'b0, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd1,  4'd10}, // R4 count
        '{1'b0, 1'b1, 1'b0, 4'd0,  1'b0, 1'b0, 4'd1,  4'd10}, // R5 en low
        '{1'b0, 1'b0, 1'b1, 4'd0,  1'b0, 1'b0, 4'd1,  4'd10}, // R5 count low
        '{1'b1, 1'b0, 1'b1, 4'd5,  1'b0, 1'b0, 4'd5,  4'd5},  // R3 load
        '{1'b1, 1'b1, 1'b1, 4'd3,  1'b0, 1'b0, 4'd3,  4'd3},  // R3 load over count
        '{1'b0, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd4,  4'd4},
        '{1'b0, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd5,  4'd5},
        '{1'b0, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd6,  4'd6},
        '{1'b0, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd0,  4'd7},  // R7 wrap
        '{1'b1, 1'b0, 1'b0, 4'd13, 1'b0, 1'b0, 4'd13, 4'd13}, // R3 stray load
        '{1'b0, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  4'd13}, // R9 recover
        '{1'b0, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd1,  4'd14},
        '{1'b0, 1'b1, 1'b1, 4'd0,  1'b0, 1'b0, 4'd2,  4'd9},  // R8 wrap
        '{1'b1, 1'b0, 1'b1, 4'd15, 1'b0, 1'b0, 4'd15, 4'd15},
        '{1'b0, 1'b1, 1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  4'd0},  // R6 carry
        '{1'b0, 1'b1, 1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  4'd0}   // R6 no carry
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int nxt7(int v);
        return (v == 6) ? 0 : v + 1;
    endfunction

    function automatic int nxt6(int v);
        return (v == 14) ? 9 : ((v + 1) % 16);
    endfunction

    initial begin
        int m7, m6;
        tick();
        tick();
        chk("R2 reset mod7", q7, 0);
        chk("R2 reset mod6", q6, 9);
        rst = 1'b0;

        for (int i = 0; i < 16; i++) begin
            load  = VEC[i].ld;
            count = VEC[i].cnt;
            en    = VEC[i].ena;
            d     = VEC[i].dat;
            #1;
            chk($sformatf("R6 co mod7 vec %0d", i), co7, VEC[i].c7);
            chk($sformatf("R6 co mod6 vec %0d", i), co6, VEC[i].c6);
            tick();
            chk($sformatf("R3/R4/R5/R7/R9 q mod7 vec %0d", i), q7, VEC[i].e7);
            chk($sformatf("R3/R4/R5/R8 q mod6 vec %0d", i), q6, VEC[i].e6);
        end

        // R10: reset outranks load
        rst = 1'b1; load = 1'b1; d = 4'd7; count = 1'b1; en = 1'b1;
        tick();
        chk("R10 rst over load mod7", q7, 0);
        chk("R10 rst over load mod6", q6, 9);
        rst = 1'b0; load = 1'b0;
        tick();
        tick();
        chk("R4 count after reset mod7", q7, 2);
        chk("R4 count after reset mod6", q6, 11);

        // R1: clear in mid-count, no clock edge needed
        aclr = 1'b1;
        #1;
        chk("R1 async clear mod7", q7, 0);
        chk("R1 async clear mod6", q6, 0);
        load = 1'b1; d = 4'd5;
        tick();
        chk("R10 clear over load mod7", q7, 0);
        chk("R10 clear over load mod6", q6, 0);
        aclr = 1'b0; load = 1'b0;

        // Reference-model run: several full periods of both sequences
        rst = 1'b1;
        tick();
        rst = 1'b0;
        m7 = 0;
        m6 = 9;
        for (int k = 0; k < 24; k++) begin
            tick();
            m7 = nxt7(m7);
            m6 = nxt6(m6);
            chk($sformatf("R7 model mod7 step %0d", k), q7, m7);
            chk($sformatf("R8 model mod6 step %0d", k), q6, m6);
        end
        count = 1'b0; en = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule